// File: doc/BRIEF.md
# Mode-Selectable Truncated-Modulus Counter

This block is a 4-bit binary counter that can step up or down, with a synchronous parallel load and a count enable. A 2-bit mode input turns it into one of four free-running counters. The modulus and the code offset are not set by clearing the counter. Each mode has a last state, called its stop state. When the counter sits at that state and the enable is high, the next clock reloads the mode's first value instead of stepping. The clear path is never used to shape the cycle.

The four modes give a modulo-8 up-counter starting at zero, a modulo-10 down-counter starting at ten, a modulo-11 down-counter starting at fifteen, and a modulo-10 up-counter in excess-3 code starting at three. A system picks the divide ratio and code with the mode pins and gates counting with the enable.

Top module: `modcount_conv`

## Requirements
- R1: While `rst_n` is low, `count` is 0000. The reset is asynchronous and does not wait for a clock edge.
- R2: On the first rising clock edge after `rst_n` goes high, `count` loads the first value of the mode on `mode`, whatever the level of `cnt_en`.
- R3: With `cnt_en` low and `mode` unchanged since the last edge, `count` keeps its value across the clock edge.
- R4: Mode 2'b00 counts up through 0,1,...,7. From 7 it returns to 0, for a cycle of 8 enabled clocks.
- R5: Mode 2'b01 counts down through 10,9,...,1. From 1 it returns to 10, for a cycle of 10 enabled clocks.
- R6: Mode 2'b10 counts down through 15,14,...,5. From 5 it returns to 15, for a cycle of 11 enabled clocks.
- R7: Mode 2'b11 counts up through 3,4,...,12. From 12 it returns to 3, for a cycle of 10 enabled clocks.
- R8: If `mode` differs from its value at the previous edge, the next edge loads the first value of the new mode. This applies whatever the level of `cnt_en` and whatever the current count.
- R9: A counter held at its stop state with `cnt_en` low stays there. The reload to the first value happens only on the next edge with `cnt_en` high.
- R10: Once a mode has been loaded and while it stays selected, `count` never leaves that mode's range of states.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cnt_en | input | 1 | Active-high count command |
| mode | input | 2 | Counter variant: 00 mod-8 up, 01 mod-10 down, 10 mod-11 down, 11 excess-3 up |
| count | output | 4 | Current counter state |

## Verification
The counter is driven through each mode's complete cycle with the enable held high. One extra step past the end of the cycle proves the cycle length and the wrap point, and it separates a correct terminal reload from an off-by-one stop state or a wrong first value. Runs with the enable low show that a hold differs from a step. The same holds when the counter sits at a stop state, which exposes a reload that ignores the enable. Mode changes in the middle of a count, with the enable low and with it high, separate a forced reload from normal stepping or terminal loading. An asynchronous reset applied during counting checks the clear path.

// File: rtl/mcc_pkg.sv
package mcc_pkg;
  localparam int CNT_W  = 4;
  localparam int MODE_W = 2;

  typedef enum logic [MODE_W-1:0] {
    MODE_OCT_UP    = 2'b00,
    MODE_DEC_DN    = 2'b01,
    MODE_ELEVEN_DN = 2'b10,
    MODE_XS3_UP    = 2'b11
  } mode_e;

  typedef logic [CNT_W-1:0] cnt_t;

  // Per-mode limits, shared by the decoder and the checker
  function automatic cnt_t first_of(input mode_e m);
    case (m)
      MODE_OCT_UP:    first_of = 4'd0;
      MODE_DEC_DN:    first_of = 4'd10;
      MODE_ELEVEN_DN: first_of = 4'd15;
      default:        first_of = 4'd3;
    endcase
  endfunction

  function automatic cnt_t stop_of(input mode_e m);
    case (m)
      MODE_OCT_UP:    stop_of = 4'd7;
      MODE_DEC_DN:    stop_of = 4'd1;
      MODE_ELEVEN_DN: stop_of = 4'd5;
      default:        stop_of = 4'd12;
    endcase
  endfunction

  function automatic logic is_down(input mode_e m);
    is_down = (m == MODE_DEC_DN) || (m == MODE_ELEVEN_DN);
  endfunction
endpackage

// File: rtl/mcc_mode_decode.sv
module mcc_mode_decode
  import mcc_pkg::*;
(
  input  mode_e mode,
  output cnt_t  first_val,
  output cnt_t  stop_val,
  output logic  down
);
  always_comb begin
    first_val = first_of(mode);
    stop_val  = stop_of(mode);
    down      = is_down(mode);
  end
endmodule

// File: rtl/mcc_term_detect.sv
module mcc_term_detect #(
  parameter int W = 4
) (
  input  logic [W-1:0] count,
  input  logic [W-1:0] stop_val,
  output logic         at_stop
);
  logic [W-1:0] match;

  for (genvar i = 0; i < W; i++) begin : g_cmp
    assign match[i] = ~(count[i] ^ stop_val[i]);
  end

  assign at_stop = &match;
endmodule

// File: rtl/mcc_reload_ctl.sv
module mcc_reload_ctl #(
  parameter int MW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [MW-1:0] mode,
  output logic          reload_req
);
  logic          primed_q;
  logic          primed_d;
  logic [MW-1:0] mode_q;
  logic [MW-1:0] mode_d;

  always_comb begin
    primed_d   = 1'b1;
    mode_d     = mode;
    reload_req = !primed_q || (mode != mode_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      primed_q <= 1'b0;
      mode_q   <= '0;
    end else begin
      primed_q <= primed_d;
      mode_q   <= mode_d;
    end
  end
endmodule

// File: rtl/mcc_updown_core.sv
module mcc_updown_core #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step_en,
  input  logic         load,
  input  logic         down,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] count
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic [W-1:0] flip;
  logic [W-1:0] chain;

  // Toggle chain: bit i flips when every lower bit is 1 (up) or 0 (down)
  assign chain[0] = 1'b1;
  for (genvar i = 0; i < W; i++) begin : g_slice
    assign flip[i] = chain[i];
    if (i < W - 1) begin : g_link
      assign chain[i+1] = chain[i] & (cnt_q[i] ^ down);
    end
  end

  always_comb begin
    cnt_d = cnt_q;
    if (load)
      cnt_d = load_val;
    else if (step_en)
      cnt_d = cnt_q ^ flip;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else
      cnt_q <= cnt_d;
  end

  assign count = cnt_q;
endmodule

// File: rtl/modcount_conv.sv
module modcount_conv
  import mcc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnt_en,
  input  logic [MODE_W-1:0] mode,
  output logic [CNT_W-1:0]  count
);
  cnt_t  first_val;
  cnt_t  stop_val;
  logic  down;
  logic  at_stop;
  logic  reload_req;
  logic  load;
  cnt_t  cnt_int;

  mcc_mode_decode u_decode (
    .mode      (mode_e'(mode)),
    .first_val (first_val),
    .stop_val  (stop_val),
    .down      (down)
  );

  mcc_term_detect #(.W(CNT_W)) u_term (
    .count    (cnt_int),
    .stop_val (stop_val),
    .at_stop  (at_stop)
  );

  mcc_reload_ctl #(.MW(MODE_W)) u_reload (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode       (mode),
    .reload_req (reload_req)
  );

  // Terminal reload obeys the count command; a forced reload does not
  assign load = reload_req || (cnt_en && at_stop);

  mcc_updown_core #(.W(CNT_W)) u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .step_en  (cnt_en),
    .load     (load),
    .down     (down),
    .load_val (first_val),
    .count    (cnt_int)
  );

  assign count = cnt_int;
endmodule

// File: rtl/mcc_checker.sv
module mcc_checker
  import mcc_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              cnt_en,
  input logic [MODE_W-1:0] mode,
  input logic [CNT_W-1:0]  count
);
  logic              ck_primed;
  logic [MODE_W-1:0] ck_mode;
  logic              settled;
  logic [CNT_W-1:0]  lo;
  logic [CNT_W-1:0]  hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ck_primed <= 1'b0;
      ck_mode   <= '0;
    end else begin
      ck_primed <= 1'b1;
      ck_mode   <= mode;
    end
  end

  assign settled = ck_primed && (mode == ck_mode);

  always_comb begin
    if (is_down(mode_e'(mode))) begin
      lo = stop_of(mode_e'(mode));
      hi = first_of(mode_e'(mode));
    end else begin
      lo = first_of(mode_e'(mode));
      hi = stop_of(mode_e'(mode));
    end
  end

  p_first_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !ck_primed |=> count == first_of(mode_e'($past(mode))));

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (settled && !cnt_en) |=> $stable(count));

  // Covers R4, R5, R6 and R7: one step per enabled clock in the mode's direction
  p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (settled && cnt_en && count != stop_of(mode_e'(mode))) |=>
      count == (is_down(mode_e'($past(mode))) ? $past(count) - 4'd1 : $past(count) + 4'd1));

  p_mode_reload_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ck_primed && mode != ck_mode) |=> count == first_of(mode_e'($past(mode))));

  p_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (settled && cnt_en && count == stop_of(mode_e'(mode))) |=>
      count == first_of(mode_e'($past(mode))));

  p_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
    settled |-> (count >= lo && count <= hi));
endmodule

bind modcount_conv mcc_checker u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .cnt_en (cnt_en),
  .mode   (mode),
  .count  (count)
);

// File: tb/modcount_conv_test.sv
`timescale 1ns/1ps
module modcount_conv_test;
  logic       clk;
  logic       rst_n;
  logic       cnt_en;
  logic [1:0] mode;
  logic [3:0] count;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 0;

  modcount_conv uut (
    .clk    (clk),
    .rst_n  (rst_n),
    .cnt_en (cnt_en),
    .mode   (mode),
    .count  (count)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // Entry fields: {mode[1:0], first[3:0], down, length[3:0]}
  localparam logic [10:0] WALK [4] = '{
    {2'b00, 4'd0,  1'b0, 4'd8},
    {2'b01, 4'd10, 1'b1, 4'd10},
    {2'b10, 4'd15, 1'b1, 4'd11},
    {2'b11, 4'd3,  1'b0, 4'd10}
  };

  task automatic chk(input string tag, input logic [3:0] got, input logic [3:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: count=%0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  function automatic string mode_tag(input logic [1:0] m);
    case (m)
      2'b00:   return "R4";
      2'b01:   return "R5";
      2'b10:   return "R6";
      default: return "R7";
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: count=%0d expected end of run", count);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n  = 1'b0;
    cnt_en = 1'b0;
    mode   = 2'b01;
    repeat (3) step();
    chk("R1 reset", count, 4'd0);

    rst_n = 1'b1;
    step();
    chk("R2 first load", count, 4'd10);

    // Table walk: reload, full cycle plus one wrap, then hold
    for (int e = 0; e < 4; e++) begin
      logic [1:0] m;
      logic [3:0] f;
      logic       dn;
      logic [3:0] len;
      {m, f, dn, len} = WALK[e];
      mode   = m;
      cnt_en = 1'b0;
      step();
      chk("R8 reload with enable low", count, f);
      cnt_en = 1'b1;
      for (int i = 1; i <= int'(len); i++) begin
        logic [3:0] ofs;
        ofs = 4'(i % int'(len));
        step();
        chk(mode_tag(m), count, dn ? f - ofs : f + ofs);
      end
      cnt_en = 1'b0;
      step();
      step();
      chk("R3 hold", count, f);
    end

    // R9: parked at stop state with enable low
    mode   = 2'b11;
    cnt_en = 1'b1;
    for (int i = 0; i < 9; i++) step();
    chk("R9 reach stop", count, 4'd12);
    cnt_en = 1'b0;
    for (int i = 0; i < 3; i++) begin
      step();
      chk("R9 parked", count, 4'd12);
    end
    cnt_en = 1'b1;
    step();
    chk("R9 reload on enable", count, 4'd3);

    // R8: mode change mid-count with enable high
    mode   = 2'b10;
    cnt_en = 1'b0;
    step();
    chk("R8 enter mode 2", count, 4'd15);
    cnt_en = 1'b1;
    step();
    step();
    chk("R6 mid count", count, 4'd13);
    mode = 2'b00;
    step();
    chk("R8 change with enable high", count, 4'd0);
    step();
    chk("R4 resume", count, 4'd1);

    // R1: asynchronous reset in the middle of counting
    step();
    #1 rst_n = 1'b0;
    #1 chk("R1 async clear", count, 4'd0);
    step();
    chk("R1 held in reset", count, 4'd0);
    rst_n  = 1'b1;
    cnt_en = 1'b0;
    mode   = 2'b10;
    step();
    chk("R2 load after reset", count, 4'd15);
    // R10 range: stepping mode 2 stays within 5..15
    cnt_en = 1'b1;
    for (int i = 0; i < 11; i++) step();
    chk("R10 back at first", count, 4'd15);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule